// File: doc/BRIEF.md
# Debug trigger state sequencer

This block sits behind a set of on-chip debug comparators and decides when a debug trigger fires. Four comparator match pulses come in, each qualified by its own enable bit. Once armed, the sequencer starts in State1 and moves among State1, State2 and State3 until a match sends it to the Final state. Reaching Final raises a one-cycle trigger pulse and disarms the sequencer.

Each intermediate state has its own 4-bit selection code. The code says which match channel sends the sequencer to which state. When several enabled matches arrive in the same cycle, a match that leads to Final wins. If none leads to Final, the lowest-numbered channel wins.

Software sets the codes through a small register bus. The three codes share one address and are reached through a 2-bit bank-select field. Code and enable writes are refused while the sequencer is armed.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the sequencer is disarmed, `seq_state` reads 01 (State1), all three selection codes and all four enable bits are zero, and `trigger` is low.
- R2: A write to address 0 sets the armed flag from data bit 0 and stores data bits 2:1 as the bank select. Writing 1 to bit 0 (re)starts the sequencer in State1. Writing 0 disarms it and leaves the state as it is. A read of address 0 returns the armed flag in bit 0, the bank in bits 2:1 and `seq_state` in bits 4:3. State encoding: 01 State1, 10 State2, 11 State3, 00 Final.
- R3: Address 1 holds the selection codes in data bits 3:0, banked by the bank select. Bank 00 reaches the State1 code, bank 01 the State2 code and bank 10 the State3 code. In bank 11 a read returns zero and a write changes nothing.
- R4: While armed, writes to address 1 (codes) and address 2 (enables) are ignored. Control writes still take effect.
- R5: Address 2 holds one enable bit per channel in bits 3:0. A match on a channel whose enable bit is clear has no effect.
- R6: Selection codes map channels (ch0..ch3) to targets, and any channel not listed has no effect:
  - 1: ch0→Final.
  - 2: ch1→Final.
  - 3: ch2→Final.
  - 4: ch3→Final.
  - 5: every channel→Final.
  - 6: ch0→State1, ch1→State3.
  - 7: ch0→State2, ch1→Final.
  - 8: ch1→State1, ch3→State3.
  - 9: ch2→State1, ch3→Final.
  - 10: ch0→Final, ch1→State3.
  - 11: ch0→State3, ch2→State2.
  - 12: ch0, ch1 and ch3→Final, ch2 ignored.
  - 13: every channel→State3.
  - 14: ch0→State1, ch1→State2, ch2→State3, ch3→Final.
- R7: Among enabled matches in one cycle, any match whose target is Final wins over all others.
- R8: When no enabled match targets Final, the lowest-numbered enabled matching channel with a target decides the next state.
- R9: Codes 0 and 15 are reserved. With a reserved code in the current state, no match causes a transition.
- R10: On entering Final, `seq_state` shows 00, `armed` drops, and `trigger` is high for exactly that first cycle.
- R11: At most one transition happens per clock. While disarmed, matches do not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| match_in | input | 4 | Comparator match pulses, one per channel |
| armed | output | 1 | Sequencer armed flag |
| seq_state | output | 2 | Current state (01 S1, 10 S2, 11 S3, 00 Final) |
| trigger | output | 1 | One-cycle pulse on entering Final |

## Verification
The assertions assume that match pulses and register writes are stable across each rising clock edge. They also assume that a control write in the same cycle as a match takes precedence. Both hold because the bench changes every input only on the falling edge. The bench also never mixes a control write with a match it means to score, and it applies each scored match pattern for exactly one cycle. It always reaches State2 and State3 through its own known navigation codes before the swept code is applied, so every expected state is taken from a defined starting point.

// File: rtl/dts_pkg.sv
package dts_pkg;

   typedef enum logic [1:0] {
      ST_FIN = 2'b00,
      ST_ONE = 2'b01,
      ST_TWO = 2'b10,
      ST_THR = 2'b11
   } seq_st_e;

   typedef enum logic [2:0] {
      TG_NONE = 3'd0,
      TG_ONE  = 3'd1,
      TG_TWO  = 3'd2,
      TG_THR  = 3'd3,
      TG_FIN  = 3'd4
   } tgt_e;

   // target of one channel under a 4-bit selection code
   function automatic tgt_e code_target(input logic [3:0] code, input int unsigned ch);
      tgt_e t [4];
      for (int i = 0; i < 4; i++) t[i] = TG_NONE;
      case (code)
         4'd1:  t[0] = TG_FIN;
         4'd2:  t[1] = TG_FIN;
         4'd3:  t[2] = TG_FIN;
         4'd4:  t[3] = TG_FIN;
         4'd5:  for (int i = 0; i < 4; i++) t[i] = TG_FIN;
         4'd6:  begin t[0] = TG_ONE; t[1] = TG_THR; end
         4'd7:  begin t[0] = TG_TWO; t[1] = TG_FIN; end
         4'd8:  begin t[1] = TG_ONE; t[3] = TG_THR; end
         4'd9:  begin t[2] = TG_ONE; t[3] = TG_FIN; end
         4'd10: begin t[0] = TG_FIN; t[1] = TG_THR; end
         4'd11: begin t[0] = TG_THR; t[2] = TG_TWO; end
         4'd12: begin t[0] = TG_FIN; t[1] = TG_FIN; t[3] = TG_FIN; end
         4'd13: for (int i = 0; i < 4; i++) t[i] = TG_THR;
         4'd14: begin t[0] = TG_ONE; t[1] = TG_TWO; t[2] = TG_THR; t[3] = TG_FIN; end
         default: ;
      endcase
      return t[ch[1:0]];
   endfunction

endpackage

// File: rtl/dts_regs.sv
module dts_regs
   import dts_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int SEL_W  = 4,
   parameter int NUM_CH = 4,
   parameter int NUM_ST = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic                          armed,
   input  seq_st_e                       seq_state,
   output logic [1:0]                    bank,
   output logic [NUM_ST-1:0][SEL_W-1:0]  sel_code,
   output logic [NUM_CH-1:0]             ch_en,
   output logic                          arm_wr,
   output logic                          disarm_wr
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(2);

   logic ctrl_wr, sel_wr, en_wr;
   logic unused_wdata;

   assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
   assign sel_wr    = reg_wr && (reg_addr == A_SEL) && !armed;
   assign en_wr     = reg_wr && (reg_addr == A_EN)  && !armed;
   assign arm_wr    = ctrl_wr &&  reg_wdata[0];
   assign disarm_wr = ctrl_wr && !reg_wdata[0];
   assign unused_wdata = ^reg_wdata[DATA_W-1:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank <= 2'b00;
      else if (ctrl_wr) bank <= reg_wdata[2:1];
   end

   for (genvar s = 0; s < NUM_ST; s++) begin : g_sel
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            sel_code[s] <= '0;
         else if (sel_wr && (bank == 2'(s)))    sel_code[s] <= reg_wdata[SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ch_en <= '0;
      else if (en_wr) ch_en <= reg_wdata[NUM_CH-1:0];
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[0]   = armed;
            reg_rdata[2:1] = bank;
            reg_rdata[4:3] = seq_state;
         end
         A_SEL: begin
            case (bank)
               2'b00:   reg_rdata[SEL_W-1:0] = sel_code[0];
               2'b01:   reg_rdata[SEL_W-1:0] = sel_code[1];
               2'b10:   reg_rdata[SEL_W-1:0] = sel_code[2];
               default: reg_rdata[SEL_W-1:0] = '0;
            endcase
         end
         A_EN:    reg_rdata[NUM_CH-1:0] = ch_en;
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/dts_arb.sv
module dts_arb
   import dts_pkg::*;
#(
   parameter int SEL_W  = 4,
   parameter int NUM_CH = 4
) (
   input  logic [SEL_W-1:0]  code,
   input  logic [NUM_CH-1:0] match_in,
   input  logic [NUM_CH-1:0] ch_en,
   output tgt_e              win_tgt
);

   tgt_e tgt_ch [NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign tgt_ch[i] = (match_in[i] && ch_en[i]) ? code_target(code, i) : TG_NONE;
   end

   always_comb begin
      logic any_fin;
      tgt_e low;
      any_fin = 1'b0;
      low     = TG_NONE;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (tgt_ch[i] == TG_FIN)       any_fin = 1'b1;
         else if (tgt_ch[i] != TG_NONE) low = tgt_ch[i];
      end
      win_tgt = any_fin ? TG_FIN : low;
   end

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
   import dts_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    arm_wr,
   input  logic    disarm_wr,
   input  tgt_e    win_tgt,
   output logic    armed,
   output seq_st_e seq_state,
   output logic    trigger
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         seq_state <= ST_ONE;
         trigger   <= 1'b0;
      end else begin
         trigger <= 1'b0;
         if (arm_wr) begin
            armed     <= 1'b1;
            seq_state <= ST_ONE;
         end else if (disarm_wr) begin
            armed <= 1'b0;
         end else if (armed) begin
            case (win_tgt)
               TG_ONE: seq_state <= ST_ONE;
               TG_TWO: seq_state <= ST_TWO;
               TG_THR: seq_state <= ST_THR;
               TG_FIN: begin
                  seq_state <= ST_FIN;
                  armed     <= 1'b0;
                  trigger   <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dts_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int SEL_W  = 4,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] match_in,
   output logic              armed,
   output logic [1:0]        seq_state,
   output logic              trigger
);

   localparam int NUM_ST = 3;

   if (NUM_CH != 4) begin : g_chk_ch
      $error("dbg_trig_seq: selection codes are defined for four channels");
   end
   if (SEL_W != 4) begin : g_chk_sel
      $error("dbg_trig_seq: selection code must be 4 bits");
   end
   if (DATA_W < 5) begin : g_chk_data
      $error("dbg_trig_seq: data width too small for control readback");
   end
   if (ADDR_W < 2) begin : g_chk_addr
      $error("dbg_trig_seq: address width too small for register map");
   end

   logic [1:0]                   bank;
   logic [NUM_ST-1:0][SEL_W-1:0] sel_code;
   logic [NUM_CH-1:0]            ch_en;
   logic                         arm_wr, disarm_wr;
   logic [SEL_W-1:0]             cur_code;
   tgt_e                         win_tgt;
   seq_st_e                      st;

   assign seq_state = st;

   dts_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
      .NUM_CH(NUM_CH), .NUM_ST(NUM_ST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .armed(armed), .seq_state(st),
      .bank(bank), .sel_code(sel_code), .ch_en(ch_en),
      .arm_wr(arm_wr), .disarm_wr(disarm_wr)
   );

   always_comb begin
      case (st)
         ST_ONE:  cur_code = sel_code[0];
         ST_TWO:  cur_code = sel_code[1];
         ST_THR:  cur_code = sel_code[2];
         default: cur_code = '0;
      endcase
   end

   dts_arb #(.SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_arb (
      .code(cur_code), .match_in(match_in), .ch_en(ch_en), .win_tgt(win_tgt)
   );

   dts_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .arm_wr(arm_wr), .disarm_wr(disarm_wr), .win_tgt(win_tgt),
      .armed(armed), .seq_state(st), .trigger(trigger)
   );

endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int SEL_W  = 4,
   parameter int NUM_CH = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     reg_wr,
   input logic [ADDR_W-1:0]        reg_addr,
   input logic [DATA_W-1:0]        reg_wdata,
   input logic                     armed,
   input logic [1:0]               seq_state,
   input logic                     trigger,
   input logic [1:0]               bank,
   input logic [2:0][SEL_W-1:0]    sel_code,
   input logic [NUM_CH-1:0]        ch_en
);

   logic ctrl_w, arm_w;
   assign ctrl_w = reg_wr && (reg_addr == ADDR_W'(0));
   assign arm_w  = ctrl_w && reg_wdata[0];

   assert_trig_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trigger |=> !trigger);

   assert_trig_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trigger |-> (seq_state == 2'b00 && !armed));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !arm_w) |=> $stable(seq_state));

   assert_arm_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_w && !armed) |=> (armed && seq_state == 2'b01));

   assert_sel_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && reg_wr && reg_addr == ADDR_W'(1)) |=> $stable(sel_code));

   assert_en_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && reg_wr && reg_addr == ADDR_W'(2)) |=> $stable(ch_en));

   assert_bank_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1) && bank == 2'b11) |=> $stable(sel_code));

   assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && seq_state == 2'b01 && (sel_code[0] == '0 || sel_code[0] == '1) && !ctrl_w)
      |=> (armed && seq_state == 2'b01));

endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .NUM_CH(NUM_CH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .armed(armed), .seq_state(seq_state),
   .trigger(trigger), .bank(bank), .sel_code(sel_code), .ch_en(ch_en)
);

// File: tb/tb_dbg_trig_seq.sv
module tb_dbg_trig_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] match_in = '0;
   logic       armed;
   logic [1:0] seq_state;
   logic       trigger;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dbg_trig_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_in(match_in),
      .armed(armed), .seq_state(seq_state), .trigger(trigger)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      reg_addr = a;
      #1;
      d = int'(reg_rdata);
   endtask

   // R6 table: targets 0 none, 1..3 state, 4 Final
   function automatic int tgt(input int code, input int ch);
      int t0, t1, t2, t3;
      t0 = 0; t1 = 0; t2 = 0; t3 = 0;
      if (code >= 1 && code <= 4) begin
         if (ch == code - 1) return 4;
         return 0;
      end
      case (code)
         5:  return 4;
         13: return 3;
         6:  begin t0 = 1; t1 = 3; end
         7:  begin t0 = 2; t1 = 4; end
         8:  begin t1 = 1; t3 = 3; end
         9:  begin t2 = 1; t3 = 4; end
         10: begin t0 = 4; t1 = 3; end
         11: begin t0 = 3; t2 = 2; end
         12: begin t0 = 4; t1 = 4; t3 = 4; end
         14: begin t0 = 1; t1 = 2; t2 = 3; t3 = 4; end
         default: ;
      endcase
      case (ch)
         0: return t0;
         1: return t1;
         2: return t2;
         default: return t3;
      endcase
   endfunction

   task automatic run_case(input int t, input int code, input int pat, input int en);
      int nxt, first, fin, tg;
      wr(2'd0, 8'h00);
      wr(2'd2, 8'(en));
      wr(2'd1, 8'(t == 1 ? code : (t == 2 ? 7 : 6)));
      wr(2'd0, 8'h02);
      wr(2'd1, 8'(t == 2 ? code : 0));
      wr(2'd0, 8'h04);
      wr(2'd1, 8'(t == 3 ? code : 0));
      wr(2'd0, 8'h05);
      if (t > 1) begin
         match_in = (t == 2) ? 4'b0001 : 4'b0010;
         @(negedge clk);
         match_in = '0;
         chk("R6 navigation", int'(seq_state), t);
      end
      match_in = 4'(pat);
      @(negedge clk);
      match_in = '0;
      first = 0; fin = 0;
      for (int ch = 0; ch < 4; ch++) begin
         if (pat[ch] && en[ch]) begin
            tg = tgt(code, ch);
            if (tg == 4) fin = 1;
            else if (tg != 0 && first == 0) first = tg;
         end
      end
      nxt = fin ? 4 : (first != 0 ? first : t);
      chk("R6 R7 R8 R9 R5 state", int'(seq_state), nxt == 4 ? 0 : nxt);
      chk("R10 armed", int'(armed), nxt == 4 ? 0 : 1);
      chk("R10 trigger", int'(trigger), nxt == 4 ? 1 : 0);
      if (nxt == 4) begin
         @(negedge clk);
         chk("R10 pulse width", int'(trigger), 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 armed", int'(armed), 0);
      chk("R1 state", int'(seq_state), 1);
      chk("R1 trigger", int'(trigger), 0);
      rd(2'd0, d); chk("R1 ctrl read", d, 8);
      rd(2'd2, d); chk("R1 enables", d, 0);
      for (int b = 0; b < 3; b++) begin
         wr(2'd0, 8'(b << 1));
         rd(2'd1, d); chk("R1 code zero", d, 0);
      end

      // R3 banked access
      wr(2'd0, 8'h00); wr(2'd1, 8'h05);
      wr(2'd0, 8'h02); wr(2'd1, 8'h09);
      wr(2'd0, 8'h04); wr(2'd1, 8'h0C);
      wr(2'd0, 8'h06); wr(2'd1, 8'h0A);
      rd(2'd1, d); chk("R3 bank11 read", d, 0);
      wr(2'd0, 8'h00); rd(2'd1, d); chk("R3 bank00", d, 5);
      wr(2'd0, 8'h02); rd(2'd1, d); chk("R3 bank01", d, 9);
      wr(2'd0, 8'h04); rd(2'd1, d); chk("R3 bank10", d, 12);

      // R4 lock while armed, R2 ctrl readback
      wr(2'd2, 8'h0F);
      wr(2'd0, 8'h05);
      rd(2'd0, d); chk("R2 ctrl armed read", d, 13);
      wr(2'd1, 8'h03);
      wr(2'd2, 8'h02);
      wr(2'd0, 8'h04);
      rd(2'd1, d); chk("R4 code locked", d, 12);
      rd(2'd2, d); chk("R4 enable locked", d, 15);
      chk("R2 disarm", int'(armed), 0);

      // R11 disarmed matches ignored
      wr(2'd0, 8'h00); wr(2'd1, 8'h05);
      match_in = 4'hF;
      @(negedge clk);
      match_in = '0;
      chk("R11 disarmed state", int'(seq_state), 1);
      chk("R11 disarmed trigger", int'(trigger), 0);

      // R2 re-arm after Final
      wr(2'd0, 8'h01);
      match_in = 4'b0100;
      @(negedge clk);
      match_in = '0;
      chk("R10 final reached", int'(seq_state), 0);
      wr(2'd0, 8'h01);
      chk("R2 rearm state", int'(seq_state), 1);
      chk("R2 rearm armed", int'(armed), 1);

      // sweeps: State1 over all enables; State2/3 with all enabled
      for (int c = 0; c < 16; c++)
         for (int p = 0; p < 16; p++)
            for (int e = 0; e < 16; e++)
               run_case(1, c, p, e);
      for (int t = 2; t <= 3; t++)
         for (int c = 0; c < 16; c++)
            for (int p = 0; p < 16; p++)
               run_case(t, c, p, 15);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule